// File: doc/BRIEF.md
# Compact 16-bit Eight-Opcode Processor Core

This block is a single-issue 16-bit core with eight general registers. Each clock cycle it executes one instruction: register and immediate arithmetic (add, bitwise and), word loads and stores, an equality branch and an absolute jump. Instructions arrive on a fetch port that answers in the same cycle. Loads and stores go through one data port. That data port can refuse a request by raising a stall input.

While the data port stalls a load or store, the core does not retire that instruction. The program counter stays where it is, no register is written, and the same request is presented again on the next cycle. The instruction therefore replays until the port accepts it. Once reset is released, the core spends one cycle loading a fixed start address into the program counter and then begins issuing.

Top module: `tiny_core`

## Requirements
- R1: While reset is held, `pc_o` is 0 and `d_req_o` and `d_we_o` are low. After reset every register reads 0.
- R2: In the first cycle after reset the core issues no request and loads `pc_o` with `START_PC` (default 16). Issue begins on the next cycle.
- R3: The opcode sits in bits [15:13]: 000 add, 001 and, 010 add-immediate, 011 and-immediate, 100 load, 101 store, 110 branch-if-equal, 111 jump. For 000 and 001, register[12:10] takes register[8:6] combined with register[2:0]. Bits 9 and 5:3 are ignored. The PC then advances by one.
- R4: For 010 and 011, register[12:10] takes register[8:6] combined with the zero-extended immediate [5:0]. All sums wrap at 16 bits.
- R5: For 100 and 101, the address `d_addr_o` is register[8:6] plus the zero-extended [5:0]. A store raises `d_we_o` and drives register[12:10] on `d_wdata_o`. A load writes `d_rdata_i` into register[12:10].
- R6: Register 0 always reads as zero, and writes to it are discarded.
- R7: Opcode 110 compares register[12:10] with register[9:7]. If they are equal, the PC loads the zero-extended [6:0]. Otherwise the PC advances by one.
- R8: Opcode 111 loads the PC with bits [12:0].
- R9: When `d_stall_i` is high in a load or store cycle, the PC holds, no register is written, and the same request is repeated in the next cycle.
- R10: `d_stall_i` has no effect on instructions that are not loads or stores.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pc_o | output | 13 | Word address of the instruction being fetched |
| instr_i | input | 16 | Instruction at `pc_o`, same cycle |
| d_req_o | output | 1 | Load or store request this cycle |
| d_we_o | output | 1 | Request is a store |
| d_addr_o | output | 16 | Data word address |
| d_wdata_o | output | 16 | Store data |
| d_rdata_i | input | 16 | Load data, same cycle as the request |
| d_stall_i | input | 1 | Data port busy; the request is not taken |

## Verification
A looping program drives every opcode through the core. The operand values are chosen so that add and and give different results, an add-immediate wraps past 0xFFFF, and the RT and RS fields carry set upper bits that must be ignored. The program runs a taken branch and a not-taken branch, a jump, and a write to register 0 that is followed by a store of that register. The data-port stall takes 0, 1 and 2 cycles in rotation, which tells a correct replay apart from a lost or double-committed access. The stall input is also pulsed during non-memory instructions, where it must change nothing.

// File: rtl/tc_pkg.sv
package tc_pkg;
  localparam int XLEN = 16;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0, OP_AND  = 3'd1, OP_ADDI = 3'd2, OP_ANDI = 3'd3,
    OP_LW   = 3'd4, OP_SW   = 3'd5, OP_BEQ  = 3'd6, OP_JMP  = 3'd7
  } op_e;

  // Result of the shared datapath: address or add for add-class ops, and otherwise.
  function automatic logic [XLEN-1:0] alu_f(op_e op, logic [XLEN-1:0] a, logic [XLEN-1:0] b);
    logic [XLEN-1:0] r;
    if (op == OP_AND || op == OP_ANDI) r = a & b;
    else                               r = a + b;
    return r;
  endfunction
endpackage

// File: rtl/tc_decode.sv
module tc_decode
  import tc_pkg::*;
#(
  parameter int PC_W = 13
) (
  input  logic [15:0]     instr,
  output op_e             op,
  output logic [2:0]      idx_a,
  output logic [2:0]      idx_b,
  output logic [2:0]      idx_c,
  output logic [XLEN-1:0] imm,
  output logic [PC_W-1:0] br_target,
  output logic [PC_W-1:0] jmp_target,
  output logic            is_mem,
  output logic            is_flow,
  output logic            wr_rd,
  output logic            use_imm
);
  always_comb begin
    op         = op_e'(instr[15:13]);
    idx_a      = instr[12:10];
    idx_b      = (op == OP_BEQ) ? instr[9:7] : instr[8:6];
    idx_c      = instr[2:0];
    imm        = XLEN'(instr[5:0]);
    br_target  = PC_W'(instr[6:0]);
    jmp_target = PC_W'(instr[12:0]);
    is_mem     = (op == OP_LW) || (op == OP_SW);
    is_flow    = (op == OP_BEQ) || (op == OP_JMP);
    wr_rd      = (op == OP_ADD) || (op == OP_AND) || (op == OP_ADDI) ||
                 (op == OP_ANDI) || (op == OP_LW);
    use_imm    = (op != OP_ADD) && (op != OP_AND);
  end
endmodule

// File: rtl/tc_regfile.sv
module tc_regfile #(
  parameter int XW   = 16,
  parameter int NREG = 8,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] ra,
  input  logic [AW-1:0] rb,
  input  logic [AW-1:0] rc,
  output logic [XW-1:0] qa,
  output logic [XW-1:0] qb,
  output logic [XW-1:0] qc,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [XW-1:0] wd
);
  logic [XW-1:0] regs [NREG];

  assign regs[0] = '0;

  for (genvar i = 1; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)                    regs[i] <= '0;
      else if (we && wa == AW'(i))   regs[i] <= wd;
    end
  end

  assign qa = regs[ra];
  assign qb = regs[rb];
  assign qc = regs[rc];
endmodule

// File: rtl/tc_pcunit.sv
module tc_pcunit #(
  parameter int          PC_W     = 13,
  parameter logic [12:0] START_PC = 13'd16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            commit,
  input  logic [PC_W-1:0] next_pc,
  output logic            started,
  output logic [PC_W-1:0] pc
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc      <= '0;
      started <= 1'b0;
    end else if (!started) begin
      pc      <= PC_W'(START_PC);
      started <= 1'b1;
    end else if (commit) begin
      pc      <= next_pc;
    end
  end
endmodule

// File: rtl/tiny_core.sv
module tiny_core
  import tc_pkg::*;
#(
  parameter int          PC_W     = 13,
  parameter int          NREG     = 8,
  parameter logic [12:0] START_PC = 13'd16
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [PC_W-1:0] pc_o,
  input  logic [15:0]     instr_i,
  output logic            d_req_o,
  output logic            d_we_o,
  output logic [XLEN-1:0] d_addr_o,
  output logic [XLEN-1:0] d_wdata_o,
  input  logic [XLEN-1:0] d_rdata_i,
  input  logic            d_stall_i
);
  op_e             op;
  logic [2:0]      idx_a, idx_b, idx_c;
  logic [XLEN-1:0] imm, qa, qb, qc, opnd_b, alu_res, wr_data;
  logic [PC_W-1:0] br_target, jmp_target, next_pc;
  logic            is_mem, is_flow, wr_rd, use_imm;
  logic            started, mem_stall, commit, beq_taken;

  tc_decode #(.PC_W(PC_W)) u_dec (
    .instr(instr_i), .op(op), .idx_a(idx_a), .idx_b(idx_b), .idx_c(idx_c),
    .imm(imm), .br_target(br_target), .jmp_target(jmp_target),
    .is_mem(is_mem), .is_flow(is_flow), .wr_rd(wr_rd), .use_imm(use_imm)
  );

  // Named internal events, also used by the checker.
  assign mem_stall = started && is_mem && d_stall_i;
  assign commit    = started && !mem_stall;
  assign beq_taken = (op == OP_BEQ) && (qa == qb);

  assign opnd_b  = use_imm ? imm : qc;
  assign alu_res = alu_f(op, qb, opnd_b);
  assign wr_data = (op == OP_LW) ? d_rdata_i : alu_res;

  tc_regfile #(.XW(XLEN), .NREG(NREG)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .ra(idx_a), .rb(idx_b), .rc(idx_c),
    .qa(qa), .qb(qb), .qc(qc),
    .we(commit && wr_rd), .wa(idx_a), .wd(wr_data)
  );

  always_comb begin
    if (op == OP_JMP)  next_pc = jmp_target;
    else if (beq_taken) next_pc = br_target;
    else                next_pc = pc_o + PC_W'(1);
  end

  tc_pcunit #(.PC_W(PC_W), .START_PC(START_PC)) u_pc (
    .clk(clk), .rst_n(rst_n), .commit(commit), .next_pc(next_pc),
    .started(started), .pc(pc_o)
  );

  assign d_req_o   = started && is_mem;
  assign d_we_o    = d_req_o && (op == OP_SW);
  assign d_addr_o  = alu_res;
  assign d_wdata_o = qa;
endmodule

// File: rtl/tiny_core_chk.sv
module tiny_core_chk #(
  parameter int          PC_W     = 13,
  parameter logic [12:0] START_PC = 13'd16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            started,
  input logic            mem_stall,
  input logic            commit,
  input logic            is_flow,
  input logic [PC_W-1:0] pc_o,
  input logic            d_req_o,
  input logic            d_we_o
);
  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_stall |=> $stable(pc_o));
  // R9
  stall_replay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_stall |=> d_req_o);
  // R2
  start_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(started) |-> pc_o == PC_W'(START_PC));
  // R2
  no_early_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !started |-> !d_req_o);
  // R5
  store_is_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
    d_we_o |-> d_req_o);
  // R3
  seq_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !is_flow) |=> pc_o == $past(pc_o) + PC_W'(1));
endmodule

bind tiny_core tiny_core_chk #(.PC_W(PC_W), .START_PC(START_PC)) u_chk (
  .clk(clk), .rst_n(rst_n), .started(started), .mem_stall(mem_stall),
  .commit(commit), .is_flow(is_flow), .pc_o(pc_o),
  .d_req_o(d_req_o), .d_we_o(d_we_o)
);

// File: tb/tiny_core_test.sv
module tiny_core_test;
  localparam int START = 16;

  logic        clk = 0, rst_n = 0;
  logic [12:0] pc_o;
  logic [15:0] instr_i, d_addr_o, d_wdata_o, d_rdata_i;
  logic        d_req_o, d_we_o, d_stall_i = 0;

  logic [15:0] imem [256];
  logic [15:0] dmem [256];
  logic [15:0] mreg [8];
  logic [12:0] mpc;
  bit          mstart;
  int          nvec = 0, nbad = 0;

  assign instr_i   = imem[pc_o[7:0]];
  assign d_rdata_i = dmem[d_addr_o[7:0]];

  tiny_core #(.START_PC(13'(START))) uut (
    .clk(clk), .rst_n(rst_n), .pc_o(pc_o), .instr_i(instr_i),
    .d_req_o(d_req_o), .d_we_o(d_we_o), .d_addr_o(d_addr_o),
    .d_wdata_o(d_wdata_o), .d_rdata_i(d_rdata_i), .d_stall_i(d_stall_i)
  );

  always #4 clk = ~clk;

  task automatic check(bit ok, string req, string what, int act, int exp);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] enc(int op, int a, int b, int c);
    return 16'((op << 13) | (a << 10) | (b << 6) | c);
  endfunction
  function automatic logic [15:0] enc_beq(int a, int b, int lab);
    return 16'((6 << 13) | (a << 10) | (b << 7) | lab);
  endfunction

  function automatic logic [15:0] rv(logic [2:0] i);
    return (i == 0) ? 16'h0 : mreg[i];
  endfunction

  function automatic string tag_of(logic [15:0] ins, bit stalled);
    case (ins[15:13])
      3'd0, 3'd1: return stalled ? "R10" : "R3";
      3'd2, 3'd3: return stalled ? "R10" : "R4";
      3'd4, 3'd5: return stalled ? "R9" : ((ins[12:10] == 0) ? "R6" : "R5");
      3'd6:       return stalled ? "R10" : "R7";
      default:    return stalled ? "R10" : "R8";
    endcase
  endfunction

  initial begin
    #(8 * 100000);
    nbad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    int pat = 0, wl = -1;
    for (int i = 0; i < 256; i++) begin imem[i] = 16'h0; dmem[i] = 16'h0; end
    for (int i = 0; i < 8; i++) mreg[i] = 16'h0;
    dmem[30] = 16'hFFFF;
    imem[16] = enc(2, 1, 0, 5);             // r1 = 5
    imem[17] = enc(2, 2, 0, 7);             // r2 = 7
    imem[18] = enc(0, 3, 1, 2);             // r3 = 12
    imem[19] = enc(1, 4, 3, 2);             // r4 = 4
    imem[20] = enc(3, 5, 3, 10);            // r5 = 8
    imem[21] = enc(5, 3, 0, 20);            // mem[20] = 12
    imem[22] = enc(4, 6, 1, 15);            // r6 = mem[20]
    imem[23] = enc(0, 7, 6, 4);             // r7 = 16
    imem[24] = enc(5, 7, 5, 13);            // mem[21] = 16
    imem[25] = enc(4, 1, 0, 30);            // r1 = FFFF
    imem[26] = enc(0, 2, 1, 2);             // r2 wraps to 6
    imem[27] = enc(2, 0, 0, 9);             // write to r0 discarded
    imem[28] = enc(5, 0, 0, 22);            // mem[22] = r0
    imem[29] = enc_beq(6, 3, 32);           // taken
    imem[30] = enc(2, 1, 0, 63);
    imem[31] = 16'hE000 | 16'd16;
    imem[32] = enc_beq(1, 2, 30);           // not taken
    imem[33] = enc(0, 3, 9, 6'b111001);     // upper field bits ignored
    imem[34] = enc(2, 3, 3, 63);            // FFFE + 63 wraps
    imem[35] = 16'hE000 | 16'd16;           // jump back

    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(pc_o == 0, "R1", "pc in reset", pc_o, 0);
    check(!d_req_o && !d_we_o, "R1", "req in reset", d_req_o, 0);
    rst_n = 1;
    mpc = 0; mstart = 0;

    for (int cyc = 0; cyc < 400; cyc++) begin
      logic [15:0] ins, addr;
      logic [2:0]  op;
      bit mem, stall;
      ins  = imem[mpc[7:0]];
      op   = ins[15:13];
      mem  = mstart && (op == 3'd4 || op == 3'd5);
      if (mem) begin
        if (wl < 0) begin wl = pat; pat = (pat + 1) % 3; end
        stall = (wl > 0);
      end else stall = (cyc % 5 == 2);
      d_stall_i = stall;
      #1;
      addr = rv(ins[8:6]) + 16'(ins[5:0]);
      check(pc_o == mpc, mstart ? tag_of(ins, stall && !mem) : "R2", "pc", pc_o, mpc);
      check(d_req_o == mem, mstart ? tag_of(ins, stall) : "R2", "req", d_req_o, mem);
      check(d_we_o == (mem && op == 3'd5), tag_of(ins, stall), "we", d_we_o, mem && op == 3'd5);
      if (mem) check(d_addr_o == addr, tag_of(ins, stall), "addr", d_addr_o, addr);
      if (mem && op == 3'd5)
        check(d_wdata_o == rv(ins[12:10]), tag_of(ins, stall), "wdata", d_wdata_o, rv(ins[12:10]));

      if (!mstart) begin
        mpc = 13'(START); mstart = 1;
      end else if (mem && stall) begin
        wl--;
      end else begin
        if (mem) wl = -1;
        mpc = mpc + 13'd1;
        case (op)
          3'd0: if (ins[12:10] != 0) mreg[ins[12:10]] = rv(ins[8:6]) + rv(ins[2:0]);
          3'd1: if (ins[12:10] != 0) mreg[ins[12:10]] = rv(ins[8:6]) & rv(ins[2:0]);
          3'd2: if (ins[12:10] != 0) mreg[ins[12:10]] = rv(ins[8:6]) + 16'(ins[5:0]);
          3'd3: if (ins[12:10] != 0) mreg[ins[12:10]] = rv(ins[8:6]) & 16'(ins[5:0]);
          3'd4: if (ins[12:10] != 0) mreg[ins[12:10]] = dmem[addr[7:0]];
          3'd5: dmem[addr[7:0]] = rv(ins[12:10]);
          3'd6: if (rv(ins[12:10]) == rv(ins[9:7])) mpc = 13'(ins[6:0]);
          default: mpc = ins[12:0];
        endcase
      end
      @(posedge clk);
      @(negedge clk);
    end

    // R5/R6: stored values land in the bench memory as the requirements say
    check(dmem[20] == 16'd12, "R5", "mem[20]", dmem[20], 12);
    check(dmem[21] == 16'd16, "R5", "mem[21]", dmem[21], 16);
    check(dmem[22] == 16'd0, "R6", "mem[22]", dmem[22], 0);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule